// File: doc/BRIEF.md
# Exception Priority and Vector Select Unit

This unit decides which exception a small 8-bit processor core enters at an instruction boundary. It watches a power-on reset condition, an edge-triggered non-maskable request, two level-sensitive hardware request lines (a fast one and a normal one), and three software-trap requests that the instruction decoder raises. When the core signals a boundary, the unit picks one winner. One clock later it presents a one-cycle take strobe, the 16-bit address of the vector to fetch, and the condition-code byte with the two interrupt mask bits updated for the chosen source.

The unit holds the two mask bits itself. All other condition-code bits are passed through from the live condition-code input. A restore port reloads both mask bits from a saved condition-code byte when the core returns from a handler. Stacking registers, fetching the vector and decoding instructions are done elsewhere in the core.

Top module: `exc_vector_arbiter`

## Requirements
- R1: While `rst_n` is low and right after it is released, `take_o` is 0 and both mask bits read 1. The first boundary after reset takes the reset exception at 0xFFFE.
- R2: Vector addresses are fixed: software trap 3 0xFFF2, software trap 2 0xFFF4, fast request 0xFFF6, normal request 0xFFF8, software trap 1 0xFFFA, non-maskable 0xFFFC, reset 0xFFFE.
- R3: When several sources are pending at one boundary, the order is reset, then non-maskable, then fast, then normal. Software traps are taken only when no hardware source is eligible, and among them the order is trap 1, then trap 2, then trap 3.
- R4: The normal request is ignored while the normal mask (condition-code bit 4) is 1. The fast request is ignored while the fast mask (bit 6) is 1. Neither mask bit blocks a software trap or the non-maskable request.
- R5: Taking reset, non-maskable, fast, normal or software trap 1 sets bit 4. Software traps 2 and 3 leave bit 4 unchanged.
- R6: Taking reset, non-maskable, fast or software trap 1 sets bit 6. The normal request and software traps 2 and 3 leave bit 6 unchanged.
- R7: Taking the normal request leaves bit 6 clear, so a fast request at a later boundary is still taken during normal-request service.
- R8: A rising edge on `nmi_i` is held pending until it is taken at a boundary. A level held high produces only one take.
- R9: The fast and normal request lines are sampled only at the boundary. A pulse that ends before the boundary is lost.
- R10: `take_o` is high for exactly the cycle after a boundary that had a winner. It is never high after a cycle without a boundary.
- R11: `restore_i` loads bit 4 and bit 6 from `restore_cc_i`. When a take happens in the same cycle, the take's mask update wins and the restore is dropped.
- R12: Bits of `cc_o` other than 4 and 6 equal the matching bits of `cc_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; arms the reset exception |
| boundary_i | input | 1 | Instruction boundary: arbitrate this cycle |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| firq_i | input | 1 | Fast request, level |
| irq_i | input | 1 | Normal request, level |
| swi1_i | input | 1 | Software trap 1 request from decoder |
| swi2_i | input | 1 | Software trap 2 request from decoder |
| swi3_i | input | 1 | Software trap 3 request from decoder |
| cc_i | input | 8 | Live condition-code byte |
| restore_i | input | 1 | Reload mask bits on return |
| restore_cc_i | input | 8 | Saved condition-code byte for reload |
| take_o | output | 1 | One-cycle exception-entry strobe |
| vector_o | output | 16 | Vector fetch address of the last taken exception |
| cc_o | output | 8 | Condition code with current mask bits |

## Verification
On every cycle, the assertions check that a take only follows a boundary and that every taken vector is one of the seven table entries. They also check the per-source mask rules: which sources set bit 4, that normal entry keeps bit 6, and that a maskable request is only taken while its mask was clear. Priority between simultaneous sources, the single take from a held non-maskable level, and the loss of a request pulse that ends before the boundary depend on stimulus history. These are shown only by the bench's directed scenarios. The same holds for a take winning over a restore in the same cycle and for the pass-through of the other condition-code bits.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  // Source code doubles as the vector slot index: vector = base + 2*code.
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_SWI3  = 3'd1,
    SRC_SWI2  = 3'd2,
    SRC_FIRQ  = 3'd3,
    SRC_IRQ   = 3'd4,
    SRC_SWI1  = 3'd5,
    SRC_NMI   = 3'd6,
    SRC_RESET = 3'd7
  } exc_src_e;

  localparam int NUM_SWI = 3;

  function automatic logic [15:0] vector_of(input logic [15:0] base,
                                            input exc_src_e src);
    logic [15:0] off;
    off = {12'd0, src, 1'b0};
    return base | off;
  endfunction

endpackage

// File: rtl/exc_nmi_latch.sv
module exc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clear_i,
  output logic pend_o
);

  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = nmi_i & ~prev_q;
    prev_d = nmi_i;
    // a fresh edge in the clearing cycle stays pending
    pend_d = rise | (pend_q & ~clear_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/exc_priority.sv
module exc_priority
  import exc_arb_pkg::*;
(
  input  logic               reset_pend_i,
  input  logic               nmi_pend_i,
  input  logic               firq_ok_i,
  input  logic               irq_ok_i,
  input  logic [NUM_SWI-1:0] swi_i,   // [0]=trap1, [1]=trap2, [2]=trap3
  output exc_src_e           src_o
);

  localparam exc_src_e SWI_SRC [NUM_SWI] = '{SRC_SWI1, SRC_SWI2, SRC_SWI3};

  exc_src_e soft_src;

  always_comb begin
    soft_src = SRC_NONE;
    for (int k = NUM_SWI - 1; k >= 0; k--) begin
      if (swi_i[k]) soft_src = SWI_SRC[k];
    end
  end

  always_comb begin
    if (reset_pend_i)    src_o = SRC_RESET;
    else if (nmi_pend_i) src_o = SRC_NMI;
    else if (firq_ok_i)  src_o = SRC_FIRQ;
    else if (irq_ok_i)   src_o = SRC_IRQ;
    else                 src_o = soft_src;
  end

endmodule

// File: rtl/exc_mask_rule.sv
module exc_mask_rule
  import exc_arb_pkg::*;
(
  input  exc_src_e src_i,
  output logic     set_i_o,
  output logic     set_f_o
);

  always_comb begin
    set_i_o = 1'b0;
    set_f_o = 1'b0;
    unique case (src_i)
      SRC_RESET, SRC_NMI, SRC_FIRQ, SRC_SWI1: begin
        set_i_o = 1'b1;
        set_f_o = 1'b1;
      end
      SRC_IRQ:  set_i_o = 1'b1;
      SRC_SWI2, SRC_SWI3, SRC_NONE: ;
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_vector_arbiter.sv
module exc_vector_arbiter
  import exc_arb_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          CC_W     = 8,
  parameter int          I_BIT    = 4,
  parameter int          F_BIT    = 6,
  parameter logic [15:0] VEC_BASE = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              nmi_i,
  input  logic              firq_i,
  input  logic              irq_i,
  input  logic              swi1_i,
  input  logic              swi2_i,
  input  logic              swi3_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              restore_i,
  input  logic [CC_W-1:0]   restore_cc_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [CC_W-1:0]   cc_o
);

  localparam logic [CC_W-1:0] I_SEL = CC_W'(1) << I_BIT;
  localparam logic [CC_W-1:0] F_SEL = CC_W'(1) << F_BIT;

  logic reset_pend_q, reset_pend_d;
  logic i_mask_q, i_mask_d;
  logic f_mask_q, f_mask_d;
  logic take_q, take_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic vec_en, mask_en;

  logic nmi_pend;
  logic nmi_clear;
  logic firq_ok, irq_ok;
  exc_src_e cand, win;
  logic set_i, set_f;
  logic rest_i, rest_f;

  exc_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_i   (nmi_i),
    .clear_i (nmi_clear),
    .pend_o  (nmi_pend)
  );

  always_comb begin
    firq_ok = firq_i & ~f_mask_q;
    irq_ok  = irq_i  & ~i_mask_q;
  end

  exc_priority u_prio (
    .reset_pend_i (reset_pend_q),
    .nmi_pend_i   (nmi_pend),
    .firq_ok_i    (firq_ok),
    .irq_ok_i     (irq_ok),
    .swi_i        ({swi3_i, swi2_i, swi1_i}),
    .src_o        (cand)
  );

  always_comb win = boundary_i ? cand : SRC_NONE;

  exc_mask_rule u_rule (
    .src_i   (win),
    .set_i_o (set_i),
    .set_f_o (set_f)
  );

  // next-state logic
  always_comb begin
    take_d       = (win != SRC_NONE);
    nmi_clear    = (win == SRC_NMI);
    reset_pend_d = reset_pend_q & ~(win == SRC_RESET);
    rest_i       = |(restore_cc_i & I_SEL);
    rest_f       = |(restore_cc_i & F_SEL);

    mask_en  = take_d | restore_i;
    i_mask_d = i_mask_q;
    f_mask_d = f_mask_q;
    if (take_d) begin
      i_mask_d = i_mask_q | set_i;
      f_mask_d = f_mask_q | set_f;
    end else if (restore_i) begin
      i_mask_d = rest_i;
      f_mask_d = rest_f;
    end

    vec_en = take_d;
    vec_d  = ADDR_W'(vector_of(VEC_BASE, win));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_pend_q <= 1'b1;
      take_q       <= 1'b0;
    end else begin
      reset_pend_q <= reset_pend_d;
      take_q       <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_mask_q <= 1'b1;
      f_mask_q <= 1'b1;
    end else if (mask_en) begin
      i_mask_q <= i_mask_d;
      f_mask_q <= f_mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  // outputs
  always_comb begin
    cc_o = cc_i & ~(I_SEL | F_SEL);
    if (i_mask_q) cc_o = cc_o | I_SEL;
    if (f_mask_q) cc_o = cc_o | F_SEL;
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;

endmodule

// File: rtl/exc_vector_arbiter_chk.sv
module exc_vector_arbiter_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          CC_W     = 8,
  parameter int          I_BIT    = 4,
  parameter int          F_BIT    = 6,
  parameter logic [15:0] VEC_BASE = 16'hFFF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [CC_W-1:0]   cc_o
);

  localparam logic [ADDR_W-1:0] V_SWI3 = ADDR_W'(VEC_BASE + 16'd2);
  localparam logic [ADDR_W-1:0] V_SWI2 = ADDR_W'(VEC_BASE + 16'd4);
  localparam logic [ADDR_W-1:0] V_FIRQ = ADDR_W'(VEC_BASE + 16'd6);
  localparam logic [ADDR_W-1:0] V_IRQ  = ADDR_W'(VEC_BASE + 16'd8);

  a_r10_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  a_r2_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vector_o[ADDR_W-1:4] == VEC_BASE[ADDR_W-1:4]) &&
               !vector_o[0] && (vector_o[3:1] != 3'd0));

  a_r5_i_set_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o != V_SWI2 && vector_o != V_SWI3) |-> cc_o[I_BIT]);

  a_r5_soft_keeps_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (vector_o == V_SWI2 || vector_o == V_SWI3)) |->
      cc_o[I_BIT] == $past(cc_o[I_BIT]));

  a_r6_irq_keeps_f: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == V_IRQ) |-> cc_o[F_BIT] == $past(cc_o[F_BIT]));

  a_r4_irq_needs_clear_i: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == V_IRQ) |-> !$past(cc_o[I_BIT]));

  a_r4_firq_needs_clear_f: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == V_FIRQ) |-> !$past(cc_o[F_BIT]));

endmodule

bind exc_vector_arbiter exc_vector_arbiter_chk #(
  .ADDR_W(ADDR_W), .CC_W(CC_W), .I_BIT(I_BIT), .F_BIT(F_BIT), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .take_o     (take_o),
  .vector_o   (vector_o),
  .cc_o       (cc_o)
);

// File: tb/exc_vector_arbiter_test.sv
module exc_vector_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i, nmi_i, firq_i, irq_i;
  logic        swi1_i, swi2_i, swi3_i;
  logic [7:0]  cc_i, restore_cc_i;
  logic        restore_i;
  logic        take_o;
  logic [15:0] vector_o;
  logic [7:0]  cc_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  exc_vector_arbiter uut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_i(nmi_i),
    .firq_i(firq_i), .irq_i(irq_i), .swi1_i(swi1_i), .swi2_i(swi2_i),
    .swi3_i(swi3_i), .cc_i(cc_i), .restore_i(restore_i),
    .restore_cc_i(restore_cc_i), .take_o(take_o), .vector_o(vector_o),
    .cc_o(cc_o)
  );

  task automatic expect_eq(input string tag, input logic [15:0] act,
                           input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One boundary cycle with the given software requests; check one cycle on.
  task automatic step(input string tag, input logic s1, input logic s2,
                      input logic s3, input logic exp_take,
                      input logic [15:0] exp_vec, input logic exp_i,
                      input logic exp_f);
    boundary_i = 1'b1; swi1_i = s1; swi2_i = s2; swi3_i = s3;
    @(negedge clk);
    boundary_i = 1'b0; swi1_i = 1'b0; swi2_i = 1'b0; swi3_i = 1'b0;
    expect_eq({tag, " take"}, {15'd0, take_o}, {15'd0, exp_take});
    if (exp_take) expect_eq({tag, " vector"}, vector_o, exp_vec);
    expect_eq({tag, " mask bit4"}, {15'd0, cc_o[4]}, {15'd0, exp_i});
    expect_eq({tag, " mask bit6"}, {15'd0, cc_o[6]}, {15'd0, exp_f});
  endtask

  task automatic restore(input logic [7:0] val);
    restore_i = 1'b1; restore_cc_i = val;
    @(negedge clk);
    restore_i = 1'b0; restore_cc_i = 8'h00;
  endtask

  task automatic t_reset;
    expect_eq("R1 take low after reset", {15'd0, take_o}, 16'd0);
    expect_eq("R1 masks set after reset", {8'd0, cc_o & 8'h50}, 16'h0050);
    step("R1 reset vector", 0, 0, 0, 1'b1, 16'hFFFE, 1'b1, 1'b1);
    step("R10 no take without source", 0, 0, 0, 1'b0, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    expect_eq("R10 no take without boundary", {15'd0, take_o}, 16'd0);
  endtask

  task automatic t_restore_passthru;
    restore(8'h00);
    expect_eq("R11 restore clears masks", {8'd0, cc_o & 8'h50}, 16'h0000);
    cc_i = 8'hFF;
    #1;
    expect_eq("R12 other bits pass", {8'd0, cc_o}, 16'h00AF);
    cc_i = 8'h00;
    restore(8'h50);
    expect_eq("R11 restore sets masks", {8'd0, cc_o & 8'h50}, 16'h0050);
  endtask

  task automatic t_soft;
    restore(8'h00);
    step("R5 R6 trap2 keeps masks", 0, 1, 0, 1'b1, 16'hFFF4, 1'b0, 1'b0);
    step("R5 R6 trap3 keeps masks", 0, 0, 1, 1'b1, 16'hFFF2, 1'b0, 1'b0);
    step("R5 R6 trap1 sets masks", 1, 0, 0, 1'b1, 16'hFFFA, 1'b1, 1'b1);
    step("R4 trap2 unmaskable", 0, 1, 0, 1'b1, 16'hFFF4, 1'b1, 1'b1);
  endtask

  task automatic t_irq_firq;
    restore(8'h00);
    irq_i = 1'b1;
    step("R5 R6 normal entry", 0, 0, 0, 1'b1, 16'hFFF8, 1'b1, 1'b0);
    step("R4 normal masked", 0, 0, 0, 1'b0, 16'h0, 1'b1, 1'b0);
    firq_i = 1'b1;
    step("R7 fast preempts normal", 0, 0, 0, 1'b1, 16'hFFF6, 1'b1, 1'b1);
    step("R4 fast masked", 0, 0, 0, 1'b0, 16'h0, 1'b1, 1'b1);
    irq_i = 1'b0; firq_i = 1'b0;
  endtask

  task automatic t_priority;
    restore(8'h00);
    nmi_i = 1'b1; firq_i = 1'b1; irq_i = 1'b1;
    @(negedge clk);
    step("R3 nmi over all", 1, 0, 0, 1'b1, 16'hFFFC, 1'b1, 1'b1);
    nmi_i = 1'b0;
    restore(8'h00);
    step("R3 fast over normal and trap", 1, 0, 0, 1'b1, 16'hFFF6, 1'b1, 1'b1);
    firq_i = 1'b0;
    restore(8'h00);
    step("R3 normal over trap", 1, 0, 0, 1'b1, 16'hFFF8, 1'b1, 1'b0);
    irq_i = 1'b0;
    step("R3 trap1 first", 1, 1, 1, 1'b1, 16'hFFFA, 1'b1, 1'b1);
    step("R3 trap2 over trap3", 0, 1, 1, 1'b1, 16'hFFF4, 1'b1, 1'b1);
  endtask

  task automatic t_nmi;
    nmi_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      expect_eq("R8 nmi waits for boundary", {15'd0, take_o}, 16'd0);
    end
    step("R8 nmi taken while masked", 0, 0, 0, 1'b1, 16'hFFFC, 1'b1, 1'b1);
    step("R8 held level no retake", 0, 0, 0, 1'b0, 16'h0, 1'b1, 1'b1);
    nmi_i = 1'b0;
  endtask

  task automatic t_level_lost;
    restore(8'h00);
    irq_i = 1'b1; firq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0; firq_i = 1'b0;
    step("R9 pulse before boundary lost", 0, 0, 0, 1'b0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_take_vs_restore;
    irq_i = 1'b1;
    restore_i = 1'b1; restore_cc_i = 8'h40;
    step("R11 take wins over restore", 0, 0, 0, 1'b1, 16'hFFF8, 1'b1, 1'b0);
    restore_i = 1'b0; restore_cc_i = 8'h00; irq_i = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    rst_n = 1'b0; boundary_i = 1'b0; nmi_i = 1'b0; firq_i = 1'b0;
    irq_i = 1'b0; swi1_i = 1'b0; swi2_i = 1'b0; swi3_i = 1'b0;
    cc_i = 8'h00; restore_i = 1'b0; restore_cc_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_restore_passthru;
    t_soft;
    t_irq_firq;
    t_priority;
    t_nmi;
    t_level_lost;
    t_take_vs_restore;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

endmodule